// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block translates a virtual address into a physical address by walking a radix tree of page tables stored in memory. A translation request carries a 48-bit virtual address and a write flag. Starting from the table whose page number sits in a root register, the walker forms the address of one 8-byte entry per level. It reads that entry over a single read port, checks its present bit and follows the page number it holds to the next table. At the fourth level the page number found there is joined with the untouched page offset to give the physical address.

A walk ends early with a page fault when an entry is not present, and the response names the level that stopped it. A write whose final entry is marked read-only ends with a protection fault. Requests are taken one at a time through a valid/ready handshake. Each walk ends with a one-cycle response pulse that carries the physical address, a fault code and a level.

Top module: `pw_walker`

## Requirements
- R1: `req_ready` is high exactly when no walk is in progress; a request is taken on a cycle where `req_valid` and `req_ready` are both high, and `req_ready` stays low from the next cycle until that walk has responded.
- R2: A pulse on `root_wr` loads `root_ppn_in` into the root register; a walk uses the root value held when its request is taken as the page number of the top-level table.
- R3: The entry address at each level is {table page number, 9-bit index, 3'b000}; the first read indexes with virtual address bits [47:39], and the following levels use [38:30], [29:21] and [20:12] in that order.
- R4: In an entry, bit 0 is the present flag, bit 1 is the read-only flag, and bits [PA_W-1:12] hold the next page number; all other entry bits have no effect on the result.
- R5: A walk makes at most four reads, issues each read as a one-cycle `mem_rd_valid` pulse, and issues the next read only after the response to the previous one.
- R6: When an entry read at level L (0 = top) has its present bit clear, the walk makes no further reads and responds with fault code 1 and level L.
- R7: A walk whose four entries are all present responds, after exactly four reads, with fault code 0, level 3 and `resp_paddr` = {page number of the last entry, virtual address bits [11:0]}.
- R8: A write request whose last-level entry is marked read-only responds with fault code 2 and level 3; a read to such an entry succeeds as in R7, and the read-only flag of upper-level entries is ignored.
- R9: Every accepted request produces exactly one `resp_valid` pulse of one cycle, after which `req_ready` is high again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| root_wr | input | 1 | Load strobe for the root register |
| root_ppn_in | input | PA_W-12 | Page number of the top-level table |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_vaddr | input | 48 | Virtual address to translate |
| req_write | input | 1 | Request is a write access |
| mem_rd_valid | output | 1 | One-cycle read request for an entry |
| mem_rd_addr | output | PA_W | Physical byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data valid |
| mem_rsp_data | input | 64 | Entry data |
| resp_valid | output | 1 | One-cycle walk result pulse |
| resp_paddr | output | PA_W | Translated physical address (zero on a fault) |
| resp_fault | output | 2 | 0 none, 1 page fault, 2 protection fault |
| resp_level | output | 2 | Level that ended the walk |

## Verification
The bench builds the walker with 2-bit indexes, four levels and a 16-bit physical address. This shrinks the virtual address to 13 bits, so every one of the 256 index paths can be walked for both reads and writes under two root values. The bench computes entries arithmetically from their addresses. They are present about ten times in eleven, are read-only by a bit pattern, and carry junk in the unused bits. The sweep therefore reaches page faults at every level, protection faults, read-only upper entries and successful walks. Memory latency varies from one to three cycles between reads.

// File: rtl/pw_pkg.sv
package pw_pkg;

    // Entry layout shared by all levels
    localparam int ENTRY_W     = 64;
    localparam int ENTRY_SHIFT = 3;   // 8-byte entries
    localparam int PRESENT_BIT = 0;
    localparam int RO_BIT      = 1;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_PAGE = 2'd1,
        FLT_PROT = 2'd2
    } fault_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_DONE
    } walk_st_e;

    // A table of 2**idx_w entries fills exactly one page
    function automatic int ofs_width(input int idx_w);
        return idx_w + ENTRY_SHIFT;
    endfunction

endpackage

// File: rtl/pw_index_sel.sv
module pw_index_sel #(
    parameter int LEVELS = 4,
    parameter int IDX_W  = 9,
    parameter int OFS_W  = pw_pkg::ofs_width(IDX_W),
    parameter int VA_W   = OFS_W + LEVELS * IDX_W,
    parameter int LVL_W  = $clog2(LEVELS)
) (
    input  logic [VA_W-1:0]  va,
    input  logic [LVL_W-1:0] lvl,
    output logic [IDX_W-1:0] idx
);

    logic [IDX_W-1:0] field [LEVELS];

    // Level 0 takes the highest slice
    for (genvar g = 0; g < LEVELS; g++) begin : g_field
        assign field[g] = va[OFS_W + IDX_W*(LEVELS-1-g) +: IDX_W];
    end

    assign idx = field[lvl];

endmodule

// File: rtl/pw_entry_dec.sv
module pw_entry_dec #(
    parameter int PA_W  = 52,
    parameter int OFS_W = 12,
    parameter int PPN_W = PA_W - OFS_W
) (
    input  logic [pw_pkg::ENTRY_W-1:0] data,
    output logic                       present,
    output logic                       ro,
    output logic [PPN_W-1:0]           ppn
);
    import pw_pkg::*;

    logic unused_bits;

    assign present     = data[PRESENT_BIT];
    assign ro          = data[RO_BIT];
    assign ppn         = data[OFS_W +: PPN_W];
    assign unused_bits = ^{data[ENTRY_W-1:PA_W], data[OFS_W-1:RO_BIT+1]};

endmodule

// File: rtl/pw_ctrl.sv
module pw_ctrl #(
    parameter int LEVELS = 4,
    parameter int IDX_W  = 9,
    parameter int PA_W   = 52,
    parameter int OFS_W  = pw_pkg::ofs_width(IDX_W),
    parameter int VA_W   = OFS_W + LEVELS * IDX_W,
    parameter int PPN_W  = PA_W - OFS_W,
    parameter int LVL_W  = $clog2(LEVELS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  va_in,
    input  logic             wr_in,
    input  logic [PPN_W-1:0] root_ppn,
    input  logic             rsp_valid,
    input  logic             ent_present,
    input  logic             ent_ro,
    input  logic [PPN_W-1:0] ent_ppn,
    output logic             rd_valid,
    output logic [LVL_W-1:0] cur_lvl,
    output logic [VA_W-1:0]  cur_va,
    output logic [PPN_W-1:0] tbl_ppn,
    output logic             resp_valid,
    output logic [PA_W-1:0]  resp_paddr,
    output pw_pkg::fault_e   resp_fault,
    output logic [LVL_W-1:0] resp_level
);
    import pw_pkg::*;

    localparam logic [LVL_W-1:0] LAST = LVL_W'(LEVELS - 1);

    walk_st_e st;
    logic     wr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            cur_lvl    <= '0;
            cur_va     <= '0;
            tbl_ppn    <= '0;
            wr_q       <= 1'b0;
            resp_paddr <= '0;
            resp_fault <= FLT_NONE;
            resp_level <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        cur_va  <= va_in;
                        wr_q    <= wr_in;
                        tbl_ppn <= root_ppn;
                        cur_lvl <= '0;
                        st      <= ST_ISSUE;
                    end
                end
                ST_ISSUE: st <= ST_WAIT;
                ST_WAIT: begin
                    if (rsp_valid) begin
                        if (!ent_present) begin
                            resp_fault <= FLT_PAGE;
                            resp_level <= cur_lvl;
                            resp_paddr <= '0;
                            st         <= ST_DONE;
                        end else if (cur_lvl == LAST) begin
                            resp_level <= cur_lvl;
                            if (wr_q && ent_ro) begin
                                resp_fault <= FLT_PROT;
                                resp_paddr <= '0;
                            end else begin
                                resp_fault <= FLT_NONE;
                                resp_paddr <= {ent_ppn, cur_va[OFS_W-1:0]};
                            end
                            st <= ST_DONE;
                        end else begin
                            tbl_ppn <= ent_ppn;
                            cur_lvl <= cur_lvl + 1'b1;
                            st      <= ST_ISSUE;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign req_ready  = (st == ST_IDLE);
    assign rd_valid   = (st == ST_ISSUE);
    assign resp_valid = (st == ST_DONE);

endmodule

// File: rtl/pw_walker.sv
module pw_walker #(
    parameter int LEVELS = 4,
    parameter int IDX_W  = 9,
    parameter int PA_W   = 52,
    parameter int OFS_W  = pw_pkg::ofs_width(IDX_W),
    parameter int VA_W   = OFS_W + LEVELS * IDX_W,
    parameter int PPN_W  = PA_W - OFS_W,
    parameter int LVL_W  = $clog2(LEVELS)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       root_wr,
    input  logic [PPN_W-1:0]           root_ppn_in,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic [VA_W-1:0]            req_vaddr,
    input  logic                       req_write,
    output logic                       mem_rd_valid,
    output logic [PA_W-1:0]            mem_rd_addr,
    input  logic                       mem_rsp_valid,
    input  logic [pw_pkg::ENTRY_W-1:0] mem_rsp_data,
    output logic                       resp_valid,
    output logic [PA_W-1:0]            resp_paddr,
    output logic [1:0]                 resp_fault,
    output logic [LVL_W-1:0]           resp_level
);
    import pw_pkg::*;

    logic [PPN_W-1:0] root_q;
    logic [PPN_W-1:0] tbl_ppn;
    logic [PPN_W-1:0] ent_ppn;
    logic [VA_W-1:0]  cur_va;
    logic [LVL_W-1:0] cur_lvl;
    logic [IDX_W-1:0] idx;
    logic             ent_present;
    logic             ent_ro;
    fault_e           fault;

    always_ff @(posedge clk) begin
        if (rst)          root_q <= '0;
        else if (root_wr) root_q <= root_ppn_in;
    end

    pw_index_sel #(
        .LEVELS(LEVELS), .IDX_W(IDX_W), .OFS_W(OFS_W), .VA_W(VA_W), .LVL_W(LVL_W)
    ) u_idx (
        .va(cur_va), .lvl(cur_lvl), .idx(idx)
    );

    pw_entry_dec #(
        .PA_W(PA_W), .OFS_W(OFS_W), .PPN_W(PPN_W)
    ) u_dec (
        .data(mem_rsp_data), .present(ent_present), .ro(ent_ro), .ppn(ent_ppn)
    );

    pw_ctrl #(
        .LEVELS(LEVELS), .IDX_W(IDX_W), .PA_W(PA_W), .OFS_W(OFS_W),
        .VA_W(VA_W), .PPN_W(PPN_W), .LVL_W(LVL_W)
    ) u_ctrl (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .va_in(req_vaddr), .wr_in(req_write), .root_ppn(root_q),
        .rsp_valid(mem_rsp_valid), .ent_present(ent_present),
        .ent_ro(ent_ro), .ent_ppn(ent_ppn),
        .rd_valid(mem_rd_valid), .cur_lvl(cur_lvl), .cur_va(cur_va),
        .tbl_ppn(tbl_ppn),
        .resp_valid(resp_valid), .resp_paddr(resp_paddr),
        .resp_fault(fault), .resp_level(resp_level)
    );

    // Entry address: table page joined with scaled index
    assign mem_rd_addr = {tbl_ppn, idx, {ENTRY_SHIFT{1'b0}}};
    assign resp_fault  = fault;

endmodule

// File: rtl/pw_checker.sv
module pw_checker #(
    parameter int LEVELS = 4,
    parameter int PA_W   = 52,
    parameter int OFS_W  = 12,
    parameter int VA_W   = 48,
    parameter int LVL_W  = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic [VA_W-1:0]  req_vaddr,
    input logic             req_write,
    input logic             mem_rd_valid,
    input logic             resp_valid,
    input logic [PA_W-1:0]  resp_paddr,
    input logic [1:0]       resp_fault,
    input logic [LVL_W-1:0] resp_level
);
    localparam int CNT_W = $clog2(LEVELS + 1) + 1;

    logic [OFS_W-1:0] cap_ofs;
    logic             cap_wr;
    logic [CNT_W-1:0] rd_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_ofs <= '0;
            cap_wr  <= 1'b0;
            rd_cnt  <= '0;
        end else if (req_valid && req_ready) begin
            cap_ofs <= req_vaddr[OFS_W-1:0];
            cap_wr  <= req_write;
            rd_cnt  <= '0;
        end else if (mem_rd_valid) begin
            rd_cnt  <= rd_cnt + 1'b1;
        end
    end

    assert_busy_after_accept_R1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    assert_read_limit_R5: assert property (@(posedge clk) disable iff (rst)
        mem_rd_valid |-> (rd_cnt < CNT_W'(LEVELS)) && !req_ready);

    assert_read_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        mem_rd_valid |=> !mem_rd_valid);

    assert_fault_level_R6: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_fault == 2'd1) |-> (resp_level == LVL_W'(rd_cnt - 1'b1)));

    assert_success_R7: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_fault == 2'd0) |->
            (rd_cnt == CNT_W'(LEVELS)) && (resp_paddr[OFS_W-1:0] == cap_ofs));

    assert_prot_write_R8: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_fault == 2'd2) |-> cap_wr && (rd_cnt == CNT_W'(LEVELS)));

    assert_resp_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        resp_valid |=> !resp_valid && req_ready);

endmodule

bind pw_walker pw_checker #(
    .LEVELS(LEVELS), .PA_W(PA_W), .OFS_W(OFS_W), .VA_W(VA_W), .LVL_W(LVL_W)
) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_write(req_write), .mem_rd_valid(mem_rd_valid),
    .resp_valid(resp_valid), .resp_paddr(resp_paddr), .resp_fault(resp_fault),
    .resp_level(resp_level)
);

// File: tb/sim_pw_walker.sv
module sim_pw_walker;

    localparam int LV = 4;
    localparam int IW = 2;
    localparam int PW = 16;
    localparam int OW = IW + 3;
    localparam int VW = OW + LV * IW;
    localparam int NW = PW - OW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          root_wr = 1'b0;
    logic [NW-1:0] root_ppn_in = '0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [VW-1:0] req_vaddr = '0;
    logic          req_write = 1'b0;
    logic          mem_rd_valid;
    logic [PW-1:0] mem_rd_addr;
    logic          mem_rsp_valid = 1'b0;
    logic [63:0]   mem_rsp_data = '0;
    logic          resp_valid;
    logic [PW-1:0] resp_paddr;
    logic [1:0]    resp_fault;
    logic [1:0]    resp_level;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int rd_total = 0;
    int lat_cnt = 0;
    logic [PW-1:0] pend;
    logic [PW-1:0] rd_log [4];

    always #5 clk = ~clk;

    pw_walker #(.LEVELS(LV), .IDX_W(IW), .PA_W(PW)) u0 (
        .clk(clk), .rst(rst), .root_wr(root_wr), .root_ppn_in(root_ppn_in),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_write(req_write), .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .resp_valid(resp_valid), .resp_paddr(resp_paddr),
        .resp_fault(resp_fault), .resp_level(resp_level)
    );

    // Entry contents computed from the entry address; junk in unused bits
    function automatic logic [63:0] ent(input logic [PW-1:0] a);
        logic [12:0] k;
        logic [63:0] d;
        k = 13'(a >> 3);
        d = {k, ~k, k, ~k, k[11:0]};
        d[0] = ((k % 13'd11) != 13'd3);
        d[1] = k[1] ^ k[4];
        d[PW-1:OW] = NW'(k * 13'd37 + 13'd11);
        return d;
    endfunction

    task automatic model(input logic [NW-1:0] root, input logic [VW-1:0] va,
                         input logic wr, output logic [PW-1:0] pa,
                         output logic [1:0] flt, output logic [1:0] lvl,
                         output int nrd, output logic [PW-1:0] first);
        logic [NW-1:0] tbl;
        logic [63:0]   e;
        logic [PW-1:0] a;
        tbl = root; pa = '0; flt = 2'd0; lvl = 2'd0; nrd = 0; first = '0;
        for (int l = 0; l < LV; l++) begin
            a = {tbl, va[OW + IW*(LV-1-l) +: IW], 3'b000};
            if (l == 0) first = a;
            e = ent(a);
            nrd++;
            lvl = 2'(l);
            if (!e[0]) begin flt = 2'd1; return; end
            if (l == LV-1) begin
                if (wr && e[1]) flt = 2'd2;
                else pa = {e[PW-1:OW], va[OW-1:0]};
                return;
            end
            tbl = e[PW-1:OW];
        end
    endtask

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Memory model with 1..3 cycle latency
    always @(posedge clk) begin
        cycles <= cycles + 1;
        mem_rsp_valid <= 1'b0;
        if (mem_rd_valid) begin
            pend <= mem_rd_addr;
            rd_log[rd_total % 4] <= mem_rd_addr;
            lat_cnt <= 1 + (rd_total % 3);
            rd_total <= rd_total + 1;
        end else if (lat_cnt > 1) begin
            lat_cnt <= lat_cnt - 1;
        end else if (lat_cnt == 1) begin
            mem_rsp_valid <= 1'b1;
            mem_rsp_data  <= ent(pend);
            lat_cnt <= 0;
        end
    end

    always @(posedge clk) begin
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic load_root(input logic [NW-1:0] r);
        @(negedge clk);
        root_ppn_in = r; root_wr = 1'b1;
        @(negedge clk);
        root_wr = 1'b0; root_ppn_in = ~r;
    endtask

    task automatic walk(input logic [NW-1:0] root, input logic [VW-1:0] va,
                        input logic wr, output logic [PW-1:0] got_pa);
        logic [PW-1:0] epa, first;
        logic [1:0]    eflt, elvl;
        int            enrd, start;
        model(root, va, wr, epa, eflt, elvl, enrd, first);
        @(negedge clk);
        req_vaddr = va; req_write = wr; req_valid = 1'b1;
        start = rd_total;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_vaddr = ~va; req_write = ~wr;
        chk(req_ready == 1'b0, "R1", "ready while busy", req_ready, 0);
        while (!resp_valid) @(negedge clk);
        // R4: junk in unused entry bits must not reach the result
        if (eflt == 2'd0)
            chk(resp_fault == 2'd0 && resp_level == 2'd3 && resp_paddr == epa,
                "R7", "paddr", resp_paddr, epa);
        else if (eflt == 2'd1)
            chk(resp_fault == 2'd1 && resp_level == elvl,
                "R6", "page fault level", {resp_fault, resp_level}, {eflt, elvl});
        else
            chk(resp_fault == 2'd2 && resp_level == 2'd3,
                "R8", "protection fault", {resp_fault, resp_level}, {eflt, elvl});
        chk((rd_total - start) == enrd, "R5", "read count", rd_total - start, enrd);
        chk(rd_log[start % 4] == first, "R3", "first entry address",
            rd_log[start % 4], first);
        got_pa = resp_paddr;
        @(negedge clk);
        chk(resp_valid == 1'b0 && req_ready == 1'b1, "R9", "single pulse then idle",
            {resp_valid, req_ready}, 2'b01);
    endtask

    initial begin
        logic [PW-1:0] pa_a, pa_b, epa, first;
        logic [1:0]    eflt, elvl;
        int            enrd;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1 && resp_valid == 1'b0 && mem_rd_valid == 1'b0,
            "R1", "reset state", {req_ready, resp_valid, mem_rd_valid}, 3'b100);

        // R2: two roots give two different model-predicted results
        load_root(11'h123);
        walk(11'h123, 13'h0A5, 1'b0, pa_a);
        load_root(11'h6A5);
        walk(11'h6A5, 13'h0A5, 1'b0, pa_b);
        model(11'h6A5, 13'h0A5, 1'b0, epa, eflt, elvl, enrd, first);
        chk(pa_b == epa, "R2", "walk after root reload", pa_b, epa);

        // Full sweep of index paths, both access types, two roots
        for (int r = 0; r < 2; r++) begin
            logic [NW-1:0] root;
            root = (r == 0) ? 11'h123 : 11'h6A5;
            load_root(root);
            for (int i = 0; i < 256; i++) begin
                for (int w = 0; w < 2; w++) begin
                    logic [VW-1:0] va;
                    logic [PW-1:0] pa;
                    va = {8'(i), 5'((i * 7 + w * 3) % 32)};
                    walk(root, va, w[0], pa);
                end
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule